// File: doc/BRIEF.md
# Receiver Power-Mode Sequencer

This block is the control state machine that decides which power domains of a low-power radio receiver are switched on. It holds a small mode-control register written by the host and decodes it into one of five idle power levels. It also watches an external shutdown pin. While that pin is high the whole block is off and the register contents are lost. When the pin falls, a fixed reset delay runs, and the block then wakes in the idle level that keeps the crystal running.

When the host sets the receive-request bit, the block brings the receive chain up in a fixed order. It enables the main regulators and waits for the crystal. It then starts the synthesizer and, if allowed, calibrates the oscillator. It waits for the synthesizer to settle, powers the front-end and calibrates the converter. Last, it switches on the demodulator. Each timed wait is a programmable number of clock cycles. Each calibration step raises a start level and waits for a done pulse from the analog side. Clearing the request bit at any point returns the block to the idle level that the register encodes.

Top module: `rx_pwr_seq`

## Requirements
- R1: After synchronous reset, and after each wake from shutdown, the block is idle (pwr_state = 1) in the crystal-on level (idle_mode = 3). The mode register reads 01h and the oscillator-calibration enable reads 1.
- R2: While shdn_pin is high, pwr_state reads 0 (off) one cycle later. Every enable output is 0, mode_q and vcocal_q read 0, and writes to either register are ignored.
- R3: After shdn_pin is sampled low, the block reports off for exactly POR_CYCLES further cycles. It becomes idle on the (POR_CYCLES+1)-th rising edge.
- R4: Mode register fields are: bit 0 crystal-on, bit 1 synthesizer-on, bit 2 receive request, bit 4 temperature sensor, bit 5 battery monitor, bit 6 wake timer. Bits 3 and 7 always read 0. idle_mode is decoded with this priority: synthesizer-on gives 4 (tune), crystal-on gives 3 (ready), either sensor bit gives 2 (sensor), wake timer gives 1 (sleep), and none of these gives 0 (standby).
- R5: In the tune level the crystal enable is 1 even when bit 0 is 0.
- R6: In idle, the low-power regulator is on. The main regulator is on for idle_mode of 2 or more. The crystal is on for idle_mode of 3 or more. The synthesizer is on only in tune. The front-end, demodulator and both calibration starts are off. The aux enable follows bit 4 OR bit 5, and the wake-timer oscillator enable follows bit 6.
- R7: The receive sequence raises enables in this order: main regulator, crystal, synthesizer, oscillator calibration, front-end, converter calibration, demodulator. The two calibration starts are never high together. In receive, every enable of the chain is on.
- R8: With crystal wait X, settle wait P, oscillator-calibration time V and converter-calibration time A (in cycles), receive is reached X+P+V+A+7 rising edges after the edge that writes the request. X counts as 0 when bit 0 or bit 1 was already set. V counts as 1 when calibration is skipped.
- R9: When vcocal_q is 0, vco_cal_go never rises and the calibration step takes one cycle.
- R10: Clearing the request bit in receive or during the sequence returns pwr_state to idle one cycle after the write. The enables then match the idle level of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| shdn_pin | input | 1 | external shutdown, high = off |
| mode_we | input | 1 | write strobe for the mode register |
| mode_wdata | input | 8 | mode register write value |
| cal_we | input | 1 | write strobe for the calibration enable |
| cal_vco_wdata | input | 1 | oscillator-calibration enable write value |
| xtal_wait | input | CNT_W | crystal start wait in cycles |
| pll_wait | input | CNT_W | synthesizer settle wait in cycles |
| vco_cal_done | input | 1 | oscillator calibration finished pulse |
| adc_cal_done | input | 1 | converter calibration finished pulse |
| mode_q | output | 8 | mode register contents |
| vcocal_q | output | 1 | oscillator-calibration enable |
| pwr_state | output | 2 | 0 off, 1 idle, 2 receive |
| idle_mode | output | 3 | decoded idle level |
| seq_busy | output | 1 | receive power-up in progress |
| en_ldo_lp | output | 1 | low-power digital regulator |
| en_ldo_main | output | 1 | main digital and analog regulators |
| en_wut_osc | output | 1 | wake timer oscillator |
| en_aux | output | 1 | sensor and battery monitor |
| en_xtal | output | 1 | crystal oscillator |
| en_pll | output | 1 | synthesizer |
| vco_cal_go | output | 1 | oscillator calibration start level |
| en_rx_fe | output | 1 | amplifier, mixer and converter |
| adc_cal_go | output | 1 | converter calibration start level |
| en_modem | output | 1 | demodulator receive enable |

## Verification
The receive sequence is started from every idle level, with calibration allowed and skipped, and with random wait counts and done latencies. The measured edge count therefore separates a skipped crystal wait from a run one, and a skipped calibration from a performed one. Requests are cancelled in the middle of the sequence and in receive, to show that the return lands on the encoded idle level and not on a fixed one. Register patterns that set several fields at once exercise the decode priority. Shutdown is asserted both in idle and in receive, and writes are attempted while the pin is high, to show that the register contents are lost and the reset delay is exact.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    typedef enum logic [2:0] {
        IM_STANDBY = 3'd0,
        IM_SLEEP   = 3'd1,
        IM_SENSOR  = 3'd2,
        IM_READY   = 3'd3,
        IM_TUNE    = 3'd4
    } idle_mode_e;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_IDLE = 2'd1,
        PS_RX   = 2'd2
    } pwr_state_e;

    // sequence states are ordered: every step after F_REG keeps the earlier enables
    typedef enum logic [3:0] {
        F_SHUT, F_POR, F_IDLE, F_REG, F_XTAL, F_PLL,
        F_VCO, F_SETTLE, F_FE, F_ADC, F_MODEM, F_RX
    } fsm_e;

    localparam int B_XTON  = 0;
    localparam int B_PLLON = 1;
    localparam int B_RXON  = 2;
    localparam int B_ENTS  = 4;
    localparam int B_ENLBD = 5;
    localparam int B_ENWT  = 6;

    localparam logic [7:0] MODE_MASK    = 8'h77;
    localparam logic [7:0] MODE_DEFAULT = 8'h01;

    typedef struct packed {
        logic ldo_lp;
        logic ldo_main;
        logic wut_osc;
        logic aux;
        logic xtal;
        logic pll;
        logic vco_go;
        logic rx_fe;
        logic adc_go;
        logic modem;
    } pwr_en_t;

    function automatic idle_mode_e decode_idle(input logic [7:0] m);
        if (m[B_PLLON])                 return IM_TUNE;
        else if (m[B_XTON])             return IM_READY;
        else if (m[B_ENTS] | m[B_ENLBD]) return IM_SENSOR;
        else if (m[B_ENWT])             return IM_SLEEP;
        else                            return IM_STANDBY;
    endfunction

    function automatic logic xtal_running(input logic [7:0] m);
        return m[B_XTON] | m[B_PLLON];
    endfunction

endpackage

// File: rtl/rxps_mode_reg.sv
module rxps_mode_reg
    import rxps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       off,
    input  logic       load_default,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       cal_we,
    input  logic       cal_wdata,
    output logic [7:0] mode_q,
    output logic       vcocal_q
);

    always_ff @(posedge clk) begin
        if (rst || load_default) begin
            mode_q   <= MODE_DEFAULT;
            vcocal_q <= 1'b1;
        end else if (off) begin
            mode_q   <= '0;
            vcocal_q <= 1'b0;
        end else begin
            if (we)
                mode_q <= wdata & MODE_MASK;
            if (cal_we)
                vcocal_q <= cal_wdata;
        end
    end

    // R2: contents are lost while the block is off
    assert_off_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (off && !load_default) |=> (mode_q == 8'h00 && !vcocal_q));

    // R1: the wake defaults are loaded
    assert_wake_default_R1: assert property (@(posedge clk) disable iff (rst)
        load_default |=> (mode_q == MODE_DEFAULT && vcocal_q));

endmodule

// File: rtl/rxps_timer.sv
module rxps_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign zero = (cnt == '0);

    // R8: an armed wait counts down one per cycle
    assert_count_down_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(val)));

endmodule

// File: rtl/rxps_fsm.sv
module rxps_fsm
    import rxps_pkg::*;
#(
    parameter int CW         = 16,
    parameter int POR_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shdn,
    input  logic [7:0]    mode_q,
    input  logic          vcocal,
    input  logic [CW-1:0] xtal_wait,
    input  logic [CW-1:0] pll_wait,
    input  logic          vco_done,
    input  logic          adc_done,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          reg_default,
    output logic          off,
    output fsm_e          st
);

    localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYCLES - 1);

    fsm_e nxt;
    logic rxon;

    assign rxon = mode_q[B_RXON];
    assign off  = shdn || (st == F_SHUT) || (st == F_POR);

    always_comb begin
        nxt         = st;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        reg_default = 1'b0;
        if (shdn) begin
            nxt = F_SHUT;
        end else begin
            case (st)
                F_SHUT: begin
                    nxt      = F_POR;
                    tmr_load = 1'b1;
                    tmr_val  = POR_LOAD;
                end
                F_POR: begin
                    if (tmr_zero) begin
                        nxt         = F_IDLE;
                        reg_default = 1'b1;
                    end
                end
                F_IDLE: begin
                    if (rxon)
                        nxt = F_REG;
                end
                default: begin
                    if (!rxon) begin
                        nxt = F_IDLE;
                    end else begin
                        case (st)
                            F_REG: begin
                                nxt      = F_XTAL;
                                tmr_load = 1'b1;
                                tmr_val  = xtal_running(mode_q) ? '0 : xtal_wait;
                            end
                            F_XTAL:   if (tmr_zero) nxt = F_PLL;
                            F_PLL:    nxt = F_VCO;
                            F_VCO: begin
                                if (!vcocal || vco_done) begin
                                    nxt      = F_SETTLE;
                                    tmr_load = 1'b1;
                                    tmr_val  = pll_wait;
                                end
                            end
                            F_SETTLE: if (tmr_zero) nxt = F_FE;
                            F_FE:     nxt = F_ADC;
                            F_ADC:    if (adc_done) nxt = F_MODEM;
                            F_MODEM:  nxt = F_RX;
                            default:  nxt = st;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= F_IDLE;
        else
            st <= nxt;
    end

    // R10: dropping the request leaves receive at once
    assert_rx_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (st >= F_REG && !rxon && !shdn) |=> (st == F_IDLE));

    // R9: a skipped calibration takes one cycle
    assert_vco_skip_R9: assert property (@(posedge clk) disable iff (rst)
        (st == F_VCO && !vcocal && rxon && !shdn) |=> (st == F_SETTLE));

    // R3: the reset delay holds until the timer expires
    assert_por_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == F_POR && !shdn && !tmr_zero) |=> (st == F_POR));

    // R2: the pin wins over every state
    assert_shdn_R2: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (st == F_SHUT));

endmodule

// File: rtl/rxps_en_map.sv
module rxps_en_map
    import rxps_pkg::*;
(
    input  fsm_e       st,
    input  logic [7:0] mode_q,
    input  logic       vcocal,
    output pwr_en_t    en,
    output pwr_state_e pstate,
    output idle_mode_e imode,
    output logic       busy
);

    logic on;
    logic seq;

    assign imode = decode_idle(mode_q);
    assign on    = !(st == F_SHUT || st == F_POR);
    assign seq   = (st >= F_REG);

    always_comb begin
        en = '0;
        if (on) begin
            en.ldo_lp   = 1'b1;
            en.wut_osc  = mode_q[B_ENWT];
            en.aux      = mode_q[B_ENTS] | mode_q[B_ENLBD];
            en.ldo_main = seq || (imode >= IM_SENSOR);
            en.xtal     = (imode >= IM_READY) || (st >= F_XTAL);
            en.pll      = (imode == IM_TUNE) || (st >= F_PLL);
            en.vco_go   = (st == F_VCO) && vcocal;
            en.rx_fe    = (st >= F_FE);
            en.adc_go   = (st == F_ADC);
            en.modem    = (st >= F_MODEM);
        end
    end

    always_comb begin
        if (!on)
            pstate = PS_OFF;
        else if (st == F_RX)
            pstate = PS_RX;
        else
            pstate = PS_IDLE;
    end

    assign busy = seq && (st != F_RX);

endmodule

// File: rtl/rx_pwr_seq.sv
module rx_pwr_seq
    import rxps_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int POR_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn_pin,
    input  logic             mode_we,
    input  logic [7:0]       mode_wdata,
    input  logic             cal_we,
    input  logic             cal_vco_wdata,
    input  logic [CNT_W-1:0] xtal_wait,
    input  logic [CNT_W-1:0] pll_wait,
    input  logic             vco_cal_done,
    input  logic             adc_cal_done,
    output logic [7:0]       mode_q,
    output logic             vcocal_q,
    output logic [1:0]       pwr_state,
    output logic [2:0]       idle_mode,
    output logic             seq_busy,
    output logic             en_ldo_lp,
    output logic             en_ldo_main,
    output logic             en_wut_osc,
    output logic             en_aux,
    output logic             en_xtal,
    output logic             en_pll,
    output logic             vco_cal_go,
    output logic             en_rx_fe,
    output logic             adc_cal_go,
    output logic             en_modem
);

    fsm_e             st;
    logic             off;
    logic             reg_default;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    pwr_en_t          en;
    pwr_state_e       pstate;
    idle_mode_e       imode;

    rxps_mode_reg u_reg (
        .clk          (clk),
        .rst          (rst),
        .off          (off),
        .load_default (reg_default),
        .we           (mode_we),
        .wdata        (mode_wdata),
        .cal_we       (cal_we),
        .cal_wdata    (cal_vco_wdata),
        .mode_q       (mode_q),
        .vcocal_q     (vcocal_q)
    );

    rxps_timer #(.CW(CNT_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    rxps_fsm #(.CW(CNT_W), .POR_CYCLES(POR_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .shdn        (shdn_pin),
        .mode_q      (mode_q),
        .vcocal      (vcocal_q),
        .xtal_wait   (xtal_wait),
        .pll_wait    (pll_wait),
        .vco_done    (vco_cal_done),
        .adc_done    (adc_cal_done),
        .tmr_zero    (tmr_zero),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .reg_default (reg_default),
        .off         (off),
        .st          (st)
    );

    rxps_en_map u_map (
        .st     (st),
        .mode_q (mode_q),
        .vcocal (vcocal_q),
        .en     (en),
        .pstate (pstate),
        .imode  (imode),
        .busy   (seq_busy)
    );

    assign pwr_state   = pstate;
    assign idle_mode   = imode;
    assign en_ldo_lp   = en.ldo_lp;
    assign en_ldo_main = en.ldo_main;
    assign en_wut_osc  = en.wut_osc;
    assign en_aux      = en.aux;
    assign en_xtal     = en.xtal;
    assign en_pll      = en.pll;
    assign vco_cal_go  = en.vco_go;
    assign en_rx_fe    = en.rx_fe;
    assign adc_cal_go  = en.adc_go;
    assign en_modem    = en.modem;

    // R2: one cycle after the pin is seen high everything is dark
    assert_shdn_dark_R2: assert property (@(posedge clk) disable iff (rst)
        shdn_pin |=> (pwr_state == 2'd0 && en == '0));

    // R5: a running synthesizer always has its reference
    assert_tune_xtal_R5: assert property (@(posedge clk) disable iff (rst)
        en_pll |-> en_xtal);

    // R7: ordering of the chain
    assert_modem_after_adc_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(en_modem) |-> $past(adc_cal_go));
    assert_fe_after_pll_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(en_rx_fe) |-> $past(en_pll));
    assert_cal_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(vco_cal_go && adc_cal_go));

    // R9: no calibration start while it is disabled
    assert_no_vco_go_R9: assert property (@(posedge clk) disable iff (rst)
        !vcocal_q |-> !vco_cal_go);

endmodule

// File: tb/rx_pwr_seq_tb_top.sv
module rx_pwr_seq_tb_top;

    localparam int CW  = 16;
    localparam int POR = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shdn_pin = 1'b0;
    logic          mode_we = 1'b0;
    logic [7:0]    mode_wdata = '0;
    logic          cal_we = 1'b0;
    logic          cal_vco_wdata = 1'b0;
    logic [CW-1:0] xtal_wait = '0;
    logic [CW-1:0] pll_wait = '0;
    logic          vco_cal_done = 1'b0;
    logic          adc_cal_done = 1'b0;
    logic [7:0]    mode_q;
    logic          vcocal_q;
    logic [1:0]    pwr_state;
    logic [2:0]    idle_mode;
    logic          seq_busy;
    logic          en_ldo_lp, en_ldo_main, en_wut_osc, en_aux, en_xtal;
    logic          en_pll, vco_cal_go, en_rx_fe, adc_cal_go, en_modem;

    int checks = 0;
    int errors = 0;
    int dv = 2;
    int da = 2;
    int vcnt = 0;
    int acnt = 0;
    int mon_bad = 0;
    int vco_rises = 0;
    logic vgo_d = 1'b0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    rx_pwr_seq #(.CNT_W(CW), .POR_CYCLES(POR)) dut_i (.*);

    // analog calibration models: done pulse after a set latency
    always @(negedge clk) begin
        vcnt = vco_cal_go ? vcnt + 1 : 0;
        vco_cal_done = vco_cal_go && (vcnt == dv);
        acnt = adc_cal_go ? acnt + 1 : 0;
        adc_cal_done = adc_cal_go && (acnt == da);
        if ((vco_cal_go && adc_cal_go) || (en_rx_fe && !en_pll) || (en_pll && !en_xtal))
            mon_bad++;
        if (vco_cal_go && !vgo_d) vco_rises++;
        vgo_d = vco_cal_go;
    end

    function automatic logic [9:0] en_vec();
        return {en_ldo_lp, en_ldo_main, en_wut_osc, en_aux, en_xtal,
                en_pll, vco_cal_go, en_rx_fe, adc_cal_go, en_modem};
    endfunction

    function automatic logic [2:0] exp_mode(input logic [7:0] m);
        if (m[1]) return 3'd4;
        if (m[0]) return 3'd3;
        if (m[4] | m[5]) return 3'd2;
        if (m[6]) return 3'd1;
        return 3'd0;
    endfunction

    function automatic logic [9:0] exp_idle_en(input logic [7:0] m);
        logic [2:0] im;
        im = exp_mode(m);
        return {1'b1, im >= 3'd2, m[6], m[4] | m[5], im >= 3'd3,
                im == 3'd4, 1'b0, 1'b0, 1'b0, 1'b0};
    endfunction

    function automatic logic [9:0] exp_rx_en(input logic [7:0] m);
        return {1'b1, 1'b1, m[6], m[4] | m[5], 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    endfunction

    function automatic int exp_rx_time(input logic [7:0] m, input int lx, input int lp,
                                       input bit vc, input int v, input int a);
        int x;
        x = (m[0] | m[1]) ? 0 : lx;
        return x + lp + (vc ? v : 1) + a + 7;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic write_cal(input logic v);
        @(negedge clk);
        cal_we = 1'b1;
        cal_vco_wdata = v;
        @(negedge clk);
        cal_we = 1'b0;
    endtask

    task automatic idle_check(input string req, input logic [7:0] m);
        write_mode(m);
        check({req, " mode_q"}, {24'd0, mode_q}, {24'd0, m & 8'h77});
        check({req, " idle_mode"}, {29'd0, idle_mode}, {29'd0, exp_mode(m)});
        check({req, " enables"}, {22'd0, en_vec()}, {22'd0, exp_idle_en(m)});
    endtask

    task automatic run_rx(input logic [7:0] m, input int lx, input int lp,
                          input bit vc, input int v, input int a);
        int n;
        int rises0;
        xtal_wait = CW'(lx);
        pll_wait = CW'(lp);
        dv = v;
        da = a;
        write_cal(vc);
        write_mode(m);
        rises0 = vco_rises;
        write_mode(m | 8'h04);
        n = 0;
        while (pwr_state != 2'd2 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R8 cycles to receive", n, exp_rx_time(m, lx, lp, vc, v, a));
        check("R7 receive enables", {22'd0, en_vec()}, {22'd0, exp_rx_en(m)});
        if (!vc) check("R9 no calibration start", vco_rises - rises0, 0);
        write_mode(m);
        check("R10 still receive on write edge", {30'd0, pwr_state}, 32'd2);
        @(negedge clk);
        check("R10 back to idle", {30'd0, pwr_state}, 32'd1);
        check("R10 idle level", {29'd0, idle_mode}, {29'd0, exp_mode(m)});
        check("R10 idle enables", {22'd0, en_vec()}, {22'd0, exp_idle_en(m)});
    endtask

    task automatic shutdown_cycle(input string ctx);
        int n;
        @(negedge clk);
        shdn_pin = 1'b1;
        @(negedge clk);
        check({"R2 off state ", ctx}, {30'd0, pwr_state}, 32'd0);
        check({"R2 enables dark ", ctx}, {22'd0, en_vec()}, 32'd0);
        check({"R2 register lost ", ctx}, {23'd0, vcocal_q, mode_q}, 32'd0);
        mode_we = 1'b1;
        mode_wdata = 8'h03;
        @(negedge clk);
        mode_we = 1'b0;
        check({"R2 write ignored ", ctx}, {24'd0, mode_q}, 32'd0);
        shdn_pin = 1'b0;
        n = 0;
        while (pwr_state != 2'd1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        check({"R3 reset delay ", ctx}, n, POR + 1);
        check({"R1 wake mode_q ", ctx}, {24'd0, mode_q}, 32'h01);
        check({"R1 wake vcocal ", ctx}, {31'd0, vcocal_q}, 32'd1);
        check({"R1 wake level ", ctx}, {29'd0, idle_mode}, 32'd3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset state", {30'd0, pwr_state}, 32'd1);
        check("R1 reset level", {29'd0, idle_mode}, 32'd3);
        check("R1 reset mode_q", {24'd0, mode_q}, 32'h01);
        check("R1 reset vcocal", {31'd0, vcocal_q}, 32'd1);
        check("R6 reset enables", {22'd0, en_vec()}, {22'd0, exp_idle_en(8'h01)});

        // R4 / R6 / R5 directed levels
        idle_check("R4 standby", 8'h00);
        idle_check("R4 sleep", 8'h40);
        idle_check("R4 sensor ts", 8'h10);
        idle_check("R6 sensor lbd", 8'h20);
        idle_check("R4 ready over wake", 8'h41);
        idle_check("R4 tune over ready", 8'h03);
        idle_check("R5 tune forces xtal", 8'h02);
        idle_check("R4 unused bits", 8'h88);
        idle_check("R6 sensor and sleep", 8'h70);

        // R8 / R9 directed sequences
        run_rx(8'h00, 10, 5, 1'b1, 3, 2);
        run_rx(8'h01, 10, 5, 1'b1, 3, 2);
        run_rx(8'h02, 12, 4, 1'b0, 3, 1);
        run_rx(8'h40, 0, 0, 1'b0, 1, 1);

        // R10 abort in the middle of the sequence
        xtal_wait = CW'(30);
        write_cal(1'b1);
        write_mode(8'h10);
        write_mode(8'h14);
        repeat (6) @(negedge clk);
        check("R10 busy mid sequence", {31'd0, seq_busy}, 32'd1);
        write_mode(8'h10);
        @(negedge clk);
        check("R10 abort to idle", {30'd0, pwr_state}, 32'd1);
        check("R10 abort enables", {22'd0, en_vec()}, {22'd0, exp_idle_en(8'h10)});

        // R2 / R3 / R1 shutdown from idle and from receive
        shutdown_cycle("idle");
        xtal_wait = CW'(3);
        pll_wait = CW'(2);
        write_mode(8'h05);
        repeat (40) @(negedge clk);
        check("R7 receive before shutdown", {30'd0, pwr_state}, 32'd2);
        shutdown_cycle("receive");

        // random levels, waits, latencies and calibration setting
        for (int i = 0; i < 40; i++) begin
            logic [7:0] m;
            m = 8'($urandom) & 8'h7B;
            run_rx(m, $urandom_range(0, 20), $urandom_range(0, 20),
                   1'($urandom), $urandom_range(1, 6), $urandom_range(1, 6));
        end

        check("R7 ordering monitor", mon_bad, 0);
        done_flag = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule